// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block decides, once per clock, whether two consecutive decoded instructions can start together in a two-pipe integer core. The older instruction is the first-slot (U) candidate. It always issues when it is valid. The younger one is the second-slot (V) candidate, and that slot has limited capability. Each candidate arrives as a descriptor from the decoder. A descriptor carries:

- a simple-instruction flag and a 3-bit class code
- displacement and immediate presence
- prefix information
- the length in bytes and a first-execution flag
- register read and write masks
- flag read and flag write bits
- push and pop markers

The decision is registered. One cycle after a valid U candidate is presented, the block reports either a pair or a single issue, together with a 3-bit reason code. The reason code names the lowest-numbered rule that refused the pair. When the pair is refused, only the U candidate issues, and the upstream queue presents the V candidate as the next U candidate. Each register mask has `LANES` bits per architectural register (sub-register lanes). The block merges the lanes, so that any partial access counts as an access to the whole register.

Class codes: 0 = move, LEA, NOP, PUSH/POP; 1 = plain ALU, INC, DEC, CMP, TEST; 2 = add-with-carry or subtract-with-borrow; 3 = shift or plain rotate; 4 = rotate through carry; 5 = near JMP, CALL or conditional jump; 6 and 7 are not simple. Mask bit `r*LANES + l` is lane `l` of register `r`. Reason codes: 0 paired, 1 no V candidate, 2 not simple, 3 slot restriction, 4 displacement plus immediate, 5 V prefix, 6 first-execution length, 7 dependency.

Top module: `dual_issue_pair_check`

## Requirements
- R1: A synchronous active-high `rst` clears `o_valid`, `o_pair` and `o_reason` at the next clock edge. Each decision appears on the outputs one clock after its inputs are sampled. After a cycle with `u_valid` low, the outputs are `o_valid`=0, `o_pair`=0 and `o_reason`=0.
- R2: When `u_valid` is high and `v_valid` is low, the outputs are a single issue with reason 1.
- R3: If either candidate has its simple flag low, or has class 6 or 7, pairing is refused with reason 2.
- R4: Pairing is refused with reason 3 in any of these cases: the U class is 5; the V class is 2, 3 or 4; or the U class is 4 with an immediate. A U shift (class 3) or U carry ALU (class 2) does not, on its own, prevent pairing.
- R5: A candidate that has both a displacement and an immediate refuses pairing with reason 4. A displacement in one candidate and an immediate in the other is allowed.
- R6: A prefixed V candidate refuses pairing with reason 5. The exception is a V of class 5 whose only prefix is the 0F escape (`v_pfx`=1 and `v_pfx_0f`=1). A prefix on the U candidate does not, on its own, prevent pairing.
- R7: When `u_first` is set and `u_len` is not 1, pairing is refused with reason 6. Lengths other than 1 are allowed when `u_first` is clear.
- R8: A register written by U and read or written by V refuses pairing with reason 7. Registers are compared whole: any lane of U's write against any lane of V's access. Write-after-read and read-after-read do not block.
- R9: U flag write followed by V flag read refuses pairing with reason 7. The exception is U of class 1 or 2 with V of class 5, which pairs.
- R10: When both candidates push, or both pop, accesses to the stack-pointer register (`SP_IDX`) are not counted as a dependency. All other registers are still checked.
- R11: When several rules apply, `o_reason` reports the lowest-numbered one.
- R12: `o_pair` is 1 with reason 0 exactly when a valid U, a valid V, and no rule from R2 to R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_valid | input | 1 | First-slot candidate present |
| v_valid | input | 1 | Second-slot candidate present |
| u_simple | input | 1 | U is a simple instruction |
| u_cls | input | 3 | U class code |
| u_disp | input | 1 | U has a displacement |
| u_imm | input | 1 | U has an immediate |
| u_pfx | input | 1 | U carries prefix bytes |
| u_pfx_0f | input | 1 | U's only prefix is the 0F escape |
| u_len | input | LEN_W | U length in bytes |
| u_first | input | 1 | U executes for the first time from cache |
| u_rd | input | NREG*LANES | U register read lanes |
| u_wr | input | NREG*LANES | U register write lanes |
| u_frd | input | 1 | U reads flags |
| u_fwr | input | 1 | U writes flags |
| u_push | input | 1 | U is a push |
| u_pop | input | 1 | U is a pop |
| v_simple | input | 1 | V is a simple instruction |
| v_cls | input | 3 | V class code |
| v_disp | input | 1 | V has a displacement |
| v_imm | input | 1 | V has an immediate |
| v_pfx | input | 1 | V carries prefix bytes |
| v_pfx_0f | input | 1 | V's only prefix is the 0F escape |
| v_len | input | LEN_W | V length in bytes |
| v_first | input | 1 | V executes for the first time from cache |
| v_rd | input | NREG*LANES | V register read lanes |
| v_wr | input | NREG*LANES | V register write lanes |
| v_frd | input | 1 | V reads flags |
| v_fwr | input | 1 | V writes flags |
| v_push | input | 1 | V is a push |
| v_pop | input | 1 | V is a pop |
| o_valid | output | 1 | A decision is reported |
| o_pair | output | 1 | Both candidates issue |
| o_reason | output | 3 | Lowest blocking rule, 0 when paired |

## Verification
The situations hardest to reach from the ports are those where only the exceptions decide the outcome. Examples are two pushes whose only shared register is the stack pointer, and a flag-writing ALU followed by a conditional jump, where the same masks with a shift in U must be refused. Priority between overlapping rules is also hard to reach, because a lower rule hides every higher one. Directed pairs are built lane by lane to isolate each exception and each overlap. A biased random stream then mixes sparse masks with rare class, prefix and first-execution values, and a behavioural model in the bench checks the outcome on every clock.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam logic [2:0] CL_MOVE   = 3'd0;
  localparam logic [2:0] CL_ALU    = 3'd1;
  localparam logic [2:0] CL_ALUC   = 3'd2;
  localparam logic [2:0] CL_SHIFT  = 3'd3;
  localparam logic [2:0] CL_ROTC   = 3'd4;
  localparam logic [2:0] CL_BRANCH = 3'd5;

  localparam logic [2:0] RS_PAIRED  = 3'd0;
  localparam logic [2:0] RS_NO_V    = 3'd1;
  localparam logic [2:0] RS_COMPLEX = 3'd2;
  localparam logic [2:0] RS_SLOT    = 3'd3;
  localparam logic [2:0] RS_DISPIMM = 3'd4;
  localparam logic [2:0] RS_PREFIX  = 3'd5;
  localparam logic [2:0] RS_FIRST   = 3'd6;
  localparam logic [2:0] RS_DEP     = 3'd7;
endpackage

// File: rtl/pair_lane_fold.sv
module pair_lane_fold #(
  parameter int NREG  = 8,
  parameter int LANES = 3
) (
  input  logic [NREG*LANES-1:0] lanes,
  output logic [NREG-1:0]       regs
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign regs[r] = |lanes[r*LANES +: LANES];
  end
endmodule

// File: rtl/pair_slot_rules.sv
module pair_slot_rules
  import pair_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             u_simple,
  input  logic             v_simple,
  input  logic [2:0]       u_cls,
  input  logic [2:0]       v_cls,
  input  logic             u_disp,
  input  logic             u_imm,
  input  logic             v_disp,
  input  logic             v_imm,
  input  logic             v_pfx,
  input  logic             v_pfx_0f,
  input  logic             u_first,
  input  logic [LEN_W-1:0] u_len,
  output logic             blk_simple,
  output logic             blk_slot,
  output logic             blk_dispimm,
  output logic             blk_prefix,
  output logic             blk_first
);
  logic v_u_only;

  assign blk_simple  = !u_simple || !v_simple || (u_cls > CL_BRANCH) || (v_cls > CL_BRANCH);
  assign v_u_only    = (v_cls == CL_SHIFT) || (v_cls == CL_ROTC) || (v_cls == CL_ALUC);
  assign blk_slot    = (u_cls == CL_BRANCH) || v_u_only || ((u_cls == CL_ROTC) && u_imm);
  assign blk_dispimm = (u_disp && u_imm) || (v_disp && v_imm);
  assign blk_prefix  = v_pfx && !((v_cls == CL_BRANCH) && v_pfx_0f);
  assign blk_first   = u_first && (u_len != LEN_W'(1));
endmodule

// File: rtl/pair_dep_check.sv
module pair_dep_check
  import pair_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int LANES  = 3,
  parameter int SP_IDX = 4
) (
  input  logic [NREG*LANES-1:0] u_wr,
  input  logic [NREG*LANES-1:0] v_rd,
  input  logic [NREG*LANES-1:0] v_wr,
  input  logic [2:0]            u_cls,
  input  logic [2:0]            v_cls,
  input  logic                  u_fwr,
  input  logic                  v_frd,
  input  logic                  u_push,
  input  logic                  u_pop,
  input  logic                  v_push,
  input  logic                  v_pop,
  output logic                  blk_dep
);
  localparam logic [NREG-1:0] SP_BIT = NREG'(1) << SP_IDX;

  logic [NREG-1:0] u_wr_reg, v_rd_reg, v_wr_reg, keep;
  logic            stack_pair, reg_hit, flag_hit, flag_excused;

  pair_lane_fold #(.NREG(NREG), .LANES(LANES)) u_fold_uw (.lanes(u_wr), .regs(u_wr_reg));
  pair_lane_fold #(.NREG(NREG), .LANES(LANES)) u_fold_vr (.lanes(v_rd), .regs(v_rd_reg));
  pair_lane_fold #(.NREG(NREG), .LANES(LANES)) u_fold_vw (.lanes(v_wr), .regs(v_wr_reg));

  assign stack_pair   = (u_push && v_push) || (u_pop && v_pop);
  assign keep         = stack_pair ? ~SP_BIT : '1;
  assign reg_hit      = |(u_wr_reg & (v_rd_reg | v_wr_reg) & keep);
  assign flag_excused = ((u_cls == CL_ALU) || (u_cls == CL_ALUC)) && (v_cls == CL_BRANCH);
  assign flag_hit     = u_fwr && v_frd && !flag_excused;
  assign blk_dep      = reg_hit || flag_hit;
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import pair_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int LANES  = 3,
  parameter int SP_IDX = 4,
  parameter int LEN_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  u_valid,
  input  logic                  v_valid,
  input  logic                  u_simple,
  input  logic [2:0]            u_cls,
  input  logic                  u_disp,
  input  logic                  u_imm,
  input  logic                  u_pfx,
  input  logic                  u_pfx_0f,
  input  logic [LEN_W-1:0]      u_len,
  input  logic                  u_first,
  input  logic [NREG*LANES-1:0] u_rd,
  input  logic [NREG*LANES-1:0] u_wr,
  input  logic                  u_frd,
  input  logic                  u_fwr,
  input  logic                  u_push,
  input  logic                  u_pop,
  input  logic                  v_simple,
  input  logic [2:0]            v_cls,
  input  logic                  v_disp,
  input  logic                  v_imm,
  input  logic                  v_pfx,
  input  logic                  v_pfx_0f,
  input  logic [LEN_W-1:0]      v_len,
  input  logic                  v_first,
  input  logic [NREG*LANES-1:0] v_rd,
  input  logic [NREG*LANES-1:0] v_wr,
  input  logic                  v_frd,
  input  logic                  v_fwr,
  input  logic                  v_push,
  input  logic                  v_pop,
  output logic                  o_valid,
  output logic                  o_pair,
  output logic [2:0]            o_reason
);
  logic blk_simple, blk_slot, blk_dispimm, blk_prefix, blk_first, blk_dep;
  logic [2:0] reason_d;
  // Descriptor fields that play no part in the decision: the U prefix is
  // legal in the first slot, and V's own length, first-run state, U reads,
  // U flag reads and V flag writes cannot create a blocking dependency.
  logic unused_ok;
  assign unused_ok = &{1'b0, u_pfx, u_pfx_0f, v_len, v_first, u_rd, u_frd, v_fwr};

  pair_slot_rules #(.LEN_W(LEN_W)) u_slot (
    .u_simple(u_simple), .v_simple(v_simple), .u_cls(u_cls), .v_cls(v_cls),
    .u_disp(u_disp), .u_imm(u_imm), .v_disp(v_disp), .v_imm(v_imm),
    .v_pfx(v_pfx), .v_pfx_0f(v_pfx_0f), .u_first(u_first), .u_len(u_len),
    .blk_simple(blk_simple), .blk_slot(blk_slot), .blk_dispimm(blk_dispimm),
    .blk_prefix(blk_prefix), .blk_first(blk_first)
  );

  pair_dep_check #(.NREG(NREG), .LANES(LANES), .SP_IDX(SP_IDX)) u_dep (
    .u_wr(u_wr), .v_rd(v_rd), .v_wr(v_wr), .u_cls(u_cls), .v_cls(v_cls),
    .u_fwr(u_fwr), .v_frd(v_frd), .u_push(u_push), .u_pop(u_pop),
    .v_push(v_push), .v_pop(v_pop), .blk_dep(blk_dep)
  );

  // Lowest-numbered blocking rule wins (R11).
  always_comb begin
    if (!v_valid)         reason_d = RS_NO_V;
    else if (blk_simple)  reason_d = RS_COMPLEX;
    else if (blk_slot)    reason_d = RS_SLOT;
    else if (blk_dispimm) reason_d = RS_DISPIMM;
    else if (blk_prefix)  reason_d = RS_PREFIX;
    else if (blk_first)   reason_d = RS_FIRST;
    else if (blk_dep)     reason_d = RS_DEP;
    else                  reason_d = RS_PAIRED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid  <= 1'b0;
      o_pair   <= 1'b0;
      o_reason <= RS_PAIRED;
    end else begin
      o_valid  <= u_valid;
      o_pair   <= u_valid && (reason_d == RS_PAIRED);
      o_reason <= u_valid ? reason_d : RS_PAIRED;
    end
  end
endmodule

// File: rtl/pair_check_sva.sv
module pair_check_sva #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             u_valid,
  input logic             v_valid,
  input logic             u_simple,
  input logic             v_disp,
  input logic             v_imm,
  input logic             v_pfx,
  input logic             v_pfx_0f,
  input logic [2:0]       v_cls,
  input logic             u_first,
  input logic [LEN_W-1:0] u_len,
  input logic             o_valid,
  input logic             o_pair,
  input logic [2:0]       o_reason
);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !u_valid |=> (!o_valid && !o_pair && o_reason == 3'd0));

  p_single_r2: assert property (@(posedge clk) disable iff (rst)
    (u_valid && !v_valid) |=> (o_valid && !o_pair && o_reason == 3'd1));

  p_complex_r3: assert property (@(posedge clk) disable iff (rst)
    (u_valid && v_valid && !u_simple) |=> (!o_pair && o_reason == 3'd2));

  p_dispimm_r5: assert property (@(posedge clk) disable iff (rst)
    (u_valid && v_valid && v_disp && v_imm) |=> !o_pair);

  p_prefix_r6: assert property (@(posedge clk) disable iff (rst)
    (u_valid && v_valid && v_pfx && !(v_cls == 3'd5 && v_pfx_0f)) |=> !o_pair);

  p_first_len_r7: assert property (@(posedge clk) disable iff (rst)
    (u_valid && v_valid && u_first && u_len != LEN_W'(1)) |=> !o_pair);
endmodule

bind dual_issue_pair_check pair_check_sva #(.LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst(rst), .u_valid(u_valid), .v_valid(v_valid),
  .u_simple(u_simple), .v_disp(v_disp), .v_imm(v_imm), .v_pfx(v_pfx),
  .v_pfx_0f(v_pfx_0f), .v_cls(v_cls), .u_first(u_first), .u_len(u_len),
  .o_valid(o_valid), .o_pair(o_pair), .o_reason(o_reason)
);

// File: tb/tb_dual_issue_pair_check.sv
module tb_dual_issue_pair_check;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int LANES = 3;
  localparam int SP = 4;
  localparam int MW = NREG * LANES;

  typedef struct packed {
    logic          simple;
    logic [2:0]    cls;
    logic          disp, imm, pfx, pfx0f;
    logic [3:0]    len;
    logic          first;
    logic [MW-1:0] rd, wr;
    logic          frd, fwr, push, pop;
  } desc_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic u_valid = 1'b0, v_valid = 1'b0;
  desc_t ud = '0, vd = '0;
  logic o_valid, o_pair;
  logic [2:0] o_reason;

  int checks = 0, errors = 0;
  bit done = 0;
  bit pend = 0;
  logic exp_valid, exp_pair;
  logic [2:0] exp_reason;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_pair_check dut (
    .clk(clk), .rst(rst), .u_valid(u_valid), .v_valid(v_valid),
    .u_simple(ud.simple), .u_cls(ud.cls), .u_disp(ud.disp), .u_imm(ud.imm),
    .u_pfx(ud.pfx), .u_pfx_0f(ud.pfx0f), .u_len(ud.len), .u_first(ud.first),
    .u_rd(ud.rd), .u_wr(ud.wr), .u_frd(ud.frd), .u_fwr(ud.fwr),
    .u_push(ud.push), .u_pop(ud.pop),
    .v_simple(vd.simple), .v_cls(vd.cls), .v_disp(vd.disp), .v_imm(vd.imm),
    .v_pfx(vd.pfx), .v_pfx_0f(vd.pfx0f), .v_len(vd.len), .v_first(vd.first),
    .v_rd(vd.rd), .v_wr(vd.wr), .v_frd(vd.frd), .v_fwr(vd.fwr),
    .v_push(vd.push), .v_pop(vd.pop),
    .o_valid(o_valid), .o_pair(o_pair), .o_reason(o_reason)
  );

  function automatic desc_t mk(input logic [2:0] cls);
    desc_t d = '0;
    d.simple = 1'b1;
    d.cls = cls;
    d.len = 4'd1;
    return d;
  endfunction

  function automatic logic [MW-1:0] ln(input int r, input int l);
    logic [MW-1:0] m = '0;
    m[r*LANES + l] = 1'b1;
    return m;
  endfunction

  // Behavioural reference for the reason code.
  function automatic logic [2:0] model(input desc_t u, input desc_t v, input logic vv);
    bit stk, dep;
    if (!vv) return 3'd1;
    if (!u.simple || !v.simple || u.cls > 3'd5 || v.cls > 3'd5) return 3'd2;
    if (u.cls == 3'd5 || v.cls == 3'd2 || v.cls == 3'd3 || v.cls == 3'd4 ||
        (u.cls == 3'd4 && u.imm)) return 3'd3;
    if ((u.disp && u.imm) || (v.disp && v.imm)) return 3'd4;
    if (v.pfx && !(v.cls == 3'd5 && v.pfx0f)) return 3'd5;
    if (u.first && u.len != 4'd1) return 3'd6;
    stk = (u.push && v.push) || (u.pop && v.pop);
    dep = 0;
    for (int b = 0; b < MW; b++)
      for (int c = 0; c < MW; c++)
        if (u.wr[b] && (v.rd[c] || v.wr[c]) && (b / LANES == c / LANES) &&
            !(stk && b / LANES == SP)) dep = 1;
    if (u.fwr && v.frd && !((u.cls == 3'd1 || u.cls == 3'd2) && v.cls == 3'd5)) dep = 1;
    return dep ? 3'd7 : 3'd0;
  endfunction

  task automatic compare();
    checks++;
    if (o_valid !== exp_valid || o_pair !== exp_pair || o_reason !== exp_reason) begin
      errors++;
      $display("FAIL %s: valid/pair/reason actual %0b/%0b/%0d expected %0b/%0b/%0d",
               exp_tag, o_valid, o_pair, o_reason, exp_valid, exp_pair, exp_reason);
    end
  endtask

  task automatic step(input logic r, input logic uv, input logic vv,
                      input desc_t u, input desc_t v, input string tag);
    @(negedge clk);
    if (pend) compare();
    rst = r; u_valid = uv; v_valid = vv; ud = u; vd = v;
    if (r || !uv) begin
      exp_valid = 0; exp_pair = 0; exp_reason = 3'd0;
    end else begin
      exp_reason = model(u, v, vv);
      exp_valid = 1;
      exp_pair = (exp_reason == 3'd0);
    end
    exp_tag = tag;
    pend = 1;
  endtask

  function automatic desc_t rnd();
    desc_t d = '0;
    d.simple = ($urandom_range(0, 9) != 0);
    d.cls = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(6, 7))
          : ($urandom_range(0, 1) == 1) ? 3'($urandom_range(0, 1)) : 3'($urandom_range(0, 5));
    d.disp = ($urandom_range(0, 3) == 0);
    d.imm = ($urandom_range(0, 3) == 0);
    d.pfx = ($urandom_range(0, 5) == 0);
    d.pfx0f = ($urandom_range(0, 1) == 1);
    d.len = 4'($urandom_range(1, 6));
    d.first = ($urandom_range(0, 3) == 0);
    if ($urandom_range(0, 1) == 1) d.rd[$urandom_range(0, MW-1)] = 1'b1;
    if ($urandom_range(0, 1) == 1) d.wr[$urandom_range(0, MW-1)] = 1'b1;
    d.frd = ($urandom_range(0, 2) == 0);
    d.fwr = ($urandom_range(0, 1) == 1);
    case ($urandom_range(0, 3))
      0: begin d.push = 1; d.rd[SP*LANES] = 1; d.wr[SP*LANES] = 1; end
      1: begin d.pop = 1; d.rd[SP*LANES] = 1; d.wr[SP*LANES] = 1; end
      default: ;
    endcase
    return d;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    desc_t a, b;
    // R1: reset state
    step(1, 1, 1, mk(3'd0), mk(3'd0), "R1 reset");
    step(1, 1, 1, mk(3'd0), mk(3'd0), "R1 reset");
    // R12: independent moves pair
    a = mk(3'd0); a.wr = ln(0, 0); a.rd = ln(1, 0);
    b = mk(3'd0); b.wr = ln(2, 0); b.rd = ln(3, 2);
    step(0, 1, 1, a, b, "R12 independent pair");
    // R1: idle cycle
    step(0, 0, 1, a, b, "R1 idle");
    // R2: no V candidate
    step(0, 1, 0, a, b, "R2 no second");
    // R3: not simple
    a = mk(3'd0); a.simple = 0;
    step(0, 1, 1, a, mk(3'd0), "R3 u complex");
    step(0, 1, 1, mk(3'd0), mk(3'd6), "R3 v class 6");
    // R4: slot restrictions
    step(0, 1, 1, mk(3'd5), mk(3'd0), "R4 branch in U");
    step(0, 1, 1, mk(3'd0), mk(3'd3), "R4 shift in V");
    step(0, 1, 1, mk(3'd0), mk(3'd2), "R4 carry alu in V");
    a = mk(3'd4); a.imm = 1;
    step(0, 1, 1, a, mk(3'd0), "R4 rotate-carry imm");
    step(0, 1, 1, mk(3'd3), mk(3'd0), "R4 shift in U pairs");
    step(0, 1, 1, mk(3'd2), mk(3'd5), "R4 carry alu in U pairs");
    // R5: displacement plus immediate
    b = mk(3'd0); b.disp = 1; b.imm = 1;
    step(0, 1, 1, mk(3'd0), b, "R5 v disp+imm");
    a = mk(3'd0); a.disp = 1; b = mk(3'd1); b.imm = 1;
    step(0, 1, 1, a, b, "R5 split disp/imm pairs");
    // R6: prefixes
    b = mk(3'd0); b.pfx = 1;
    step(0, 1, 1, mk(3'd0), b, "R6 v prefix");
    b = mk(3'd5); b.pfx = 1; b.pfx0f = 1;
    step(0, 1, 1, mk(3'd1), b, "R6 0F on branch pairs");
    b = mk(3'd0); b.pfx = 1; b.pfx0f = 1;
    step(0, 1, 1, mk(3'd1), b, "R6 0F on move blocks");
    a = mk(3'd0); a.pfx = 1;
    step(0, 1, 1, a, mk(3'd0), "R6 u prefix pairs");
    // R7: first execution length
    a = mk(3'd0); a.first = 1; a.len = 4'd2;
    step(0, 1, 1, a, mk(3'd0), "R7 first long");
    a.len = 4'd1;
    step(0, 1, 1, a, mk(3'd0), "R7 first one byte pairs");
    a.first = 0; a.len = 4'd3;
    step(0, 1, 1, a, mk(3'd0), "R7 later long pairs");
    // R8: register dependencies with lane aliasing
    a = mk(3'd0); a.wr = ln(0, 0);
    b = mk(3'd1); b.rd = ln(0, 1);
    step(0, 1, 1, a, b, "R8 raw across lanes");
    b = mk(3'd0); b.wr = ln(0, 2);
    step(0, 1, 1, a, b, "R8 waw across lanes");
    a = mk(3'd0); a.rd = ln(1, 0); a.wr = ln(2, 0);
    b = mk(3'd1); b.wr = ln(1, 0); b.rd = ln(1, 0);
    step(0, 1, 1, a, b, "R8 war pairs");
    // R9: flags
    a = mk(3'd1); a.fwr = 1; b = mk(3'd5); b.frd = 1;
    step(0, 1, 1, a, b, "R9 alu then jcc pairs");
    a = mk(3'd3); a.fwr = 1;
    step(0, 1, 1, a, b, "R9 shift then jcc blocks");
    a = mk(3'd1); a.fwr = 1; b = mk(3'd1); b.frd = 1;
    step(0, 1, 1, a, b, "R9 alu then flag-reading alu blocks");
    // R10: stack pointer exception
    a = mk(3'd0); a.push = 1; a.rd = ln(SP, 0) | ln(0, 0); a.wr = ln(SP, 0);
    b = mk(3'd0); b.push = 1; b.rd = ln(SP, 0) | ln(1, 0); b.wr = ln(SP, 0);
    step(0, 1, 1, a, b, "R10 push push pairs");
    b.push = 0; b.pop = 1; b.wr = ln(SP, 0) | ln(3, 0);
    step(0, 1, 1, a, b, "R10 push pop blocks");
    a = mk(3'd0); a.pop = 1; a.rd = ln(SP, 0); a.wr = ln(SP, 0) | ln(2, 1);
    b = mk(3'd0); b.pop = 1; b.rd = ln(SP, 0) | ln(2, 0); b.wr = ln(SP, 0);
    step(0, 1, 1, a, b, "R10 pop pop other reg blocks");
    // R11: priority
    a = mk(3'd0); a.wr = ln(0, 0);
    b = mk(3'd0); b.pfx = 1; b.rd = ln(0, 0);
    step(0, 1, 1, a, b, "R11 prefix over dependency");
    a = mk(3'd5); a.disp = 1; a.imm = 1; a.simple = 0;
    step(0, 1, 1, a, mk(3'd0), "R11 complex over slot");
    // R1: reset mid-stream
    step(1, 1, 1, mk(3'd0), mk(3'd0), "R1 reset mid run");
    // R12: random mix
    for (int i = 0; i < 400; i++)
      step(0, ($urandom_range(0, 7) != 0), ($urandom_range(0, 5) != 0), rnd(), rnd(), "R12 random");
    step(0, 0, 0, '0, '0, "R1 final idle");
    step(0, 0, 0, '0, '0, "R1 final idle");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule